// File: doc/BRIEF.md
# Miss status holding register file

This block follows the cache-line fills that are still outstanding for a non-blocking, in-order load path. When a load misses, the block either opens a new tracking entry for the missed line and sends one memory request, or adds the load to the entry that already covers that line, and sends no request. Each entry holds the line address and, for each word of the line, the destination register that waits on that word. The load then leaves the pipeline and does not hold it up.

A full/empty bit for each architectural register marks the registers whose load data has not yet returned. The decode stage presents its two source register numbers and receives a stall whenever either one is still empty. When a fill response comes back for an entry, the block issues a register write for every word that has a waiting destination, in that same cycle. It also frees the entry and marks those registers full, so the decode stall clears on the next cycle.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is busy and every register is full. A decode check on any register does not stall, and the first miss is accepted with a memory request for entry 0.
- R2: A miss whose line (the word address shifted right by 3) matches no busy entry, while an entry is free, is accepted in the same cycle. mem_req_valid is high, mem_req_line equals the line and mem_req_id names the allocated entry.
- R3: From the cycle after a miss is accepted, its destination register is empty and the decode check stalls when dec_src_a or dec_src_b names it.
- R4: A miss to the line of a busy entry, on a word that has no waiting destination, merges into that entry. It does not stall and raises no memory request.
- R5: A miss to a word of a busy entry that already has a waiting destination stalls and raises no request.
- R6: When all 4 entries are busy, a miss to a line that none of them holds stalls and raises no request.
- R7: A fill for a busy entry asserts wb_en bit w, for each word w that has a waiting destination, in the same cycle. wb_reg word w carries that destination and wb_data word w carries fill_data bits [32w+31:32w]. From the next cycle the entry is free and those registers are full.
- R8: If a fill and a merging miss target the same entry in one cycle, the miss stalls. On the next cycle the same miss is taken as a new miss and allocates an entry.
- R9: A miss whose destination register is already empty stalls, even if its line and word could otherwise be tracked.
- R10: A fill naming a free entry writes no register (wb_en is all zero) and changes no state.
- R11: A new line takes the lowest-numbered free entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A load miss is presented |
| miss_addr | input | 16 | Word address of the missing load |
| miss_dst | input | 5 | Destination register of the load |
| miss_stall | output | 1 | Miss not accepted this cycle |
| mem_req_valid | output | 1 | Line fill request issued |
| mem_req_line | output | 13 | Line address of the request |
| mem_req_id | output | 2 | Entry that will receive the fill |
| fill_valid | input | 1 | Fill response present |
| fill_id | input | 2 | Entry the fill belongs to |
| fill_data | input | 256 | Whole line, word w at bits [32w+31:32w] |
| wb_en | output | 8 | Per-word register write enable |
| wb_reg | output | 40 | Per-word destination register, 5 bits each |
| wb_data | output | 256 | Per-word write data, 32 bits each |
| dec_src_a | input | 5 | First decode source register |
| dec_src_b | input | 5 | Second decode source register |
| dec_stall | output | 1 | A decode source is still empty |

## Verification
miss_stall, mem_req_valid, mem_req_line, mem_req_id and the wb_* outputs respond combinationally in the cycle the stimulus is applied. Entry occupancy and the full/empty bits change at the next rising edge, so dec_stall and any later accept or stall show that change one cycle after the stimulus. The bench drives each vector 1 ns after a rising edge and samples at the following falling edge. It checks same-cycle results on the vector that caused them and state effects on the next vector.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  // Outcome of the miss-port decision for the current cycle
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ALLOC = 2'd1,
    ACT_MERGE = 2'd2,
    ACT_HOLD  = 2'd3
  } miss_act_e;
endpackage

// File: rtl/mshr_entry.sv
module mshr_entry #(
  parameter int LINE_W = 13,
  parameter int WORDS  = 8,
  parameter int REG_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_en,
  input  logic                     merge_en,
  input  logic                     free_en,
  input  logic [$clog2(WORDS)-1:0] word_sel,
  input  logic [REG_W-1:0]         dst_in,
  input  logic [LINE_W-1:0]        line_in,
  output logic                     valid_o,
  output logic [LINE_W-1:0]        line_o,
  output logic [WORDS-1:0]         wvalid_o,
  output logic [WORDS*REG_W-1:0]   wdst_o
);
  logic                   valid_q, valid_d;
  logic [LINE_W-1:0]      line_q, line_d;
  logic [WORDS-1:0]       wv_q, wv_d;
  logic [WORDS*REG_W-1:0] wd_q, wd_d;
  logic                   upd_en;

  assign upd_en = free_en | alloc_en | merge_en;

  always_comb begin
    valid_d = valid_q;
    line_d  = line_q;
    wv_d    = wv_q;
    wd_d    = wd_q;
    if (free_en) begin
      valid_d = 1'b0;
      wv_d    = '0;
    end else if (alloc_en) begin
      valid_d  = 1'b1;
      line_d   = line_in;
      wv_d     = '0;
      wv_d[word_sel] = 1'b1;
      wd_d[int'(word_sel)*REG_W +: REG_W] = dst_in;
    end else if (merge_en) begin
      wv_d[word_sel] = 1'b1;
      wd_d[int'(word_sel)*REG_W +: REG_W] = dst_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      line_q  <= '0;
      wv_q    <= '0;
      wd_q    <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      line_q  <= line_d;
      wv_q    <= wv_d;
      wd_q    <= wd_d;
    end
  end

  assign valid_o  = valid_q;
  assign line_o   = line_q;
  assign wvalid_o = wv_q;
  assign wdst_o   = wd_q;
endmodule

// File: rtl/mshr_lookup.sv
module mshr_lookup #(
  parameter int NUM_ENT = 4,
  parameter int LINE_W  = 13,
  parameter int WORDS   = 8
) (
  input  logic [NUM_ENT-1:0]         ent_valid,
  input  logic [NUM_ENT*LINE_W-1:0]  ent_line,
  input  logic [NUM_ENT*WORDS-1:0]   ent_wvalid,
  input  logic [LINE_W-1:0]          miss_line,
  input  logic [$clog2(WORDS)-1:0]   miss_word,
  input  logic                       fill_valid,
  input  logic [$clog2(NUM_ENT)-1:0] fill_id,
  output logic                       hit,
  output logic [$clog2(NUM_ENT)-1:0] hit_idx,
  output logic                       slot_busy,
  output logic                       fill_clash,
  output logic                       any_free,
  output logic [$clog2(NUM_ENT)-1:0] free_idx
);
  localparam int IDX_W = $clog2(NUM_ENT);

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    any_free = 1'b0;
    free_idx = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (ent_valid[i] && ent_line[i*LINE_W +: LINE_W] == miss_line) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
    // descending walk leaves the lowest free index
    for (int i = NUM_ENT-1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign slot_busy  = hit && ent_wvalid[int'(hit_idx)*WORDS + int'(miss_word)];
  assign fill_clash = hit && fill_valid && (fill_id == hit_idx);
endmodule

// File: rtl/mshr_scoreboard.sv
module mshr_scoreboard #(
  parameter int NREG  = 32,
  parameter int WORDS = 8,
  parameter int REG_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en,
  input  logic [REG_W-1:0]       set_reg,
  input  logic [WORDS-1:0]       clr_en,
  input  logic [WORDS*REG_W-1:0] clr_reg,
  input  logic [REG_W-1:0]       src_a,
  input  logic [REG_W-1:0]       src_b,
  input  logic [REG_W-1:0]       chk_reg,
  output logic [NREG-1:0]        empty_o,
  output logic                   dec_stall,
  output logic                   chk_busy
);
  logic [NREG-1:0] empty_q, empty_d;
  logic            upd_en;

  assign upd_en = set_en | (|clr_en);

  always_comb begin
    empty_d = empty_q;
    for (int w = 0; w < WORDS; w++) begin
      if (clr_en[w]) empty_d[clr_reg[w*REG_W +: REG_W]] = 1'b0;
    end
    if (set_en) empty_d[set_reg] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      empty_q <= '0;
    else if (upd_en) empty_q <= empty_d;
  end

  assign empty_o   = empty_q;
  assign dec_stall = empty_q[src_a] | empty_q[src_b];
  assign chk_busy  = empty_q[chk_reg];
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int NUM_ENT = 4,
  parameter int WORDS   = 8,
  parameter int NREG    = 32,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          miss_valid,
  input  logic [ADDR_W-1:0]             miss_addr,
  input  logic [$clog2(NREG)-1:0]       miss_dst,
  output logic                          miss_stall,
  output logic                          mem_req_valid,
  output logic [ADDR_W-$clog2(WORDS)-1:0] mem_req_line,
  output logic [$clog2(NUM_ENT)-1:0]    mem_req_id,
  input  logic                          fill_valid,
  input  logic [$clog2(NUM_ENT)-1:0]    fill_id,
  input  logic [WORDS*DATA_W-1:0]       fill_data,
  output logic [WORDS-1:0]              wb_en,
  output logic [WORDS*$clog2(NREG)-1:0] wb_reg,
  output logic [WORDS*DATA_W-1:0]       wb_data,
  input  logic [$clog2(NREG)-1:0]       dec_src_a,
  input  logic [$clog2(NREG)-1:0]       dec_src_b,
  output logic                          dec_stall
);
  import mshr_pkg::*;

  localparam int IDX_W  = $clog2(NUM_ENT);
  localparam int WIDX_W = $clog2(WORDS);
  localparam int REG_W  = $clog2(NREG);
  localparam int LINE_W = ADDR_W - WIDX_W;

  logic [NUM_ENT-1:0]         ent_valid;
  logic [NUM_ENT*LINE_W-1:0]  ent_line;
  logic [NUM_ENT*WORDS-1:0]   ent_wvalid;
  logic [NUM_ENT*WORDS*REG_W-1:0] ent_wdst;
  logic [NREG-1:0]            sb_empty;

  logic [LINE_W-1:0] miss_line;
  logic [WIDX_W-1:0] miss_word;
  logic              hit, slot_busy, fill_clash, any_free, dst_busy, fill_hit;
  logic [IDX_W-1:0]  hit_idx, free_idx;
  miss_act_e         act;

  assign miss_line = miss_addr[ADDR_W-1:WIDX_W];
  assign miss_word = miss_addr[WIDX_W-1:0];
  assign fill_hit  = fill_valid && ent_valid[fill_id];

  mshr_lookup #(.NUM_ENT(NUM_ENT), .LINE_W(LINE_W), .WORDS(WORDS)) lookup_i (
    .ent_valid (ent_valid),
    .ent_line  (ent_line),
    .ent_wvalid(ent_wvalid),
    .miss_line (miss_line),
    .miss_word (miss_word),
    .fill_valid(fill_valid),
    .fill_id   (fill_id),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .slot_busy (slot_busy),
    .fill_clash(fill_clash),
    .any_free  (any_free),
    .free_idx  (free_idx)
  );

  // Miss decision: destination hazard, then line match, then allocation
  always_comb begin
    act = ACT_NONE;
    if (miss_valid) begin
      if (dst_busy)                      act = ACT_HOLD;
      else if (hit) begin
        if (fill_clash || slot_busy)     act = ACT_HOLD;
        else                             act = ACT_MERGE;
      end else if (any_free)             act = ACT_ALLOC;
      else                               act = ACT_HOLD;
    end
  end

  assign miss_stall    = (act == ACT_HOLD);
  assign mem_req_valid = (act == ACT_ALLOC);
  assign mem_req_line  = miss_line;
  assign mem_req_id    = free_idx;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ENT; gi++) begin : g_ent
      logic alloc_en, merge_en, free_en;
      assign alloc_en = (act == ACT_ALLOC) && (free_idx == IDX_W'(gi));
      assign merge_en = (act == ACT_MERGE) && (hit_idx == IDX_W'(gi));
      assign free_en  = fill_hit && (fill_id == IDX_W'(gi));

      mshr_entry #(.LINE_W(LINE_W), .WORDS(WORDS), .REG_W(REG_W)) ent_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc_en(alloc_en),
        .merge_en(merge_en),
        .free_en (free_en),
        .word_sel(miss_word),
        .dst_in  (miss_dst),
        .line_in (miss_line),
        .valid_o (ent_valid[gi]),
        .line_o  (ent_line[gi*LINE_W +: LINE_W]),
        .wvalid_o(ent_wvalid[gi*WORDS +: WORDS]),
        .wdst_o  (ent_wdst[gi*WORDS*REG_W +: WORDS*REG_W])
      );
    end

    for (gi = 0; gi < WORDS; gi++) begin : g_wb
      assign wb_en[gi] = fill_hit && ent_wvalid[int'(fill_id)*WORDS + gi];
      assign wb_reg[gi*REG_W +: REG_W] =
        ent_wdst[(int'(fill_id)*WORDS + gi)*REG_W +: REG_W];
      assign wb_data[gi*DATA_W +: DATA_W] = fill_data[gi*DATA_W +: DATA_W];
    end
  endgenerate

  mshr_scoreboard #(.NREG(NREG), .WORDS(WORDS), .REG_W(REG_W)) sb_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   ((act == ACT_ALLOC) || (act == ACT_MERGE)),
    .set_reg  (miss_dst),
    .clr_en   (wb_en),
    .clr_reg  (wb_reg),
    .src_a    (dec_src_a),
    .src_b    (dec_src_b),
    .chk_reg  (miss_dst),
    .empty_o  (sb_empty),
    .dec_stall(dec_stall),
    .chk_busy (dst_busy)
  );
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int NUM_ENT = 4,
  parameter int WORDS   = 8,
  parameter int NREG    = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       miss_valid,
  input logic [$clog2(NREG)-1:0]    miss_dst,
  input logic                       miss_stall,
  input logic                       mem_req_valid,
  input logic                       fill_valid,
  input logic [$clog2(NUM_ENT)-1:0] fill_id,
  input logic [WORDS-1:0]           wb_en,
  input logic [NUM_ENT-1:0]         ent_valid,
  input logic [NREG-1:0]            sb_empty
);
  // R2
  req_needs_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (miss_valid && !miss_stall));

  // R3
  dst_empty_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !miss_stall) |=> sb_empty[$past(miss_dst)]);

  // R6
  full_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&ent_valid) |-> !mem_req_valid);

  // R7
  fill_frees_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && ent_valid[fill_id]) |=> !ent_valid[$past(fill_id)]);

  // R9
  busy_dst_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && sb_empty[miss_dst]) |-> miss_stall);

  // R10
  idle_fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !ent_valid[fill_id]) |-> (wb_en == '0));
endmodule

bind mshr_file mshr_file_chk #(.NUM_ENT(NUM_ENT), .WORDS(WORDS), .NREG(NREG)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .miss_valid   (miss_valid),
  .miss_dst     (miss_dst),
  .miss_stall   (miss_stall),
  .mem_req_valid(mem_req_valid),
  .fill_valid   (fill_valid),
  .fill_id      (fill_id),
  .wb_en        (wb_en),
  .ent_valid    (ent_valid),
  .sb_empty     (sb_empty)
);

// File: tb/mshr_file_tb_top.sv
module mshr_file_tb_top;
  // vector: req[46:43] mv[42] addr[41:26] dst[25:21] fv[20] fid[19:18]
  //         src[17:13] e_stall[12] e_req[11] e_id[10:9] e_wb[8:1] e_dec[0]
  localparam int NV = 17;
  localparam logic [46:0] VEC [NV] = '{
    {4'd1, 1'b0,16'h0000,5'd0, 1'b0,2'd0, 5'd1, 1'b0,1'b0,2'd0,8'h00,1'b0}, // R1 idle
    {4'd2, 1'b1,16'h0080,5'd1, 1'b0,2'd0, 5'd1, 1'b0,1'b1,2'd0,8'h00,1'b0}, // R2 alloc e0
    {4'd3, 1'b0,16'h0000,5'd0, 1'b0,2'd0, 5'd1, 1'b0,1'b0,2'd0,8'h00,1'b1}, // R3 r1 empty
    {4'd4, 1'b1,16'h0083,5'd2, 1'b0,2'd0, 5'd2, 1'b0,1'b0,2'd0,8'h00,1'b0}, // R4 merge
    {4'd5, 1'b1,16'h0083,5'd3, 1'b0,2'd0, 5'd2, 1'b1,1'b0,2'd0,8'h00,1'b1}, // R5 same word
    {4'd11,1'b1,16'h0100,5'd4, 1'b0,2'd0, 5'd0, 1'b0,1'b1,2'd1,8'h00,1'b0}, // R11 e1
    {4'd11,1'b1,16'h0180,5'd5, 1'b0,2'd0, 5'd0, 1'b0,1'b1,2'd2,8'h00,1'b0}, // R11 e2
    {4'd11,1'b1,16'h0200,5'd6, 1'b0,2'd0, 5'd0, 1'b0,1'b1,2'd3,8'h00,1'b0}, // R11 e3
    {4'd6, 1'b1,16'h0280,5'd7, 1'b0,2'd0, 5'd0, 1'b1,1'b0,2'd0,8'h00,1'b0}, // R6 full
    {4'd9, 1'b1,16'h0081,5'd1, 1'b0,2'd0, 5'd0, 1'b1,1'b0,2'd0,8'h00,1'b0}, // R9 dst empty
    {4'd7, 1'b0,16'h0000,5'd0, 1'b1,2'd0, 5'd1, 1'b0,1'b0,2'd0,8'h09,1'b1}, // R7 fill e0
    {4'd7, 1'b0,16'h0000,5'd0, 1'b0,2'd0, 5'd2, 1'b0,1'b0,2'd0,8'h00,1'b0}, // R7 r2 full
    {4'd11,1'b1,16'h0280,5'd7, 1'b0,2'd0, 5'd7, 1'b0,1'b1,2'd0,8'h00,1'b0}, // R11 reuse e0
    {4'd8, 1'b1,16'h0101,5'd8, 1'b1,2'd1, 5'd4, 1'b1,1'b0,2'd0,8'h01,1'b1}, // R8 clash
    {4'd8, 1'b1,16'h0101,5'd8, 1'b0,2'd0, 5'd4, 1'b0,1'b1,2'd1,8'h00,1'b0}, // R8 new miss
    {4'd7, 1'b0,16'h0000,5'd0, 1'b1,2'd2, 5'd5, 1'b0,1'b0,2'd0,8'h01,1'b1}, // R7 fill e2
    {4'd10,1'b0,16'h0000,5'd0, 1'b1,2'd2, 5'd5, 1'b0,1'b0,2'd0,8'h00,1'b0}  // R10 free fill
  };

  logic         clk, rst_n;
  logic         miss_valid, miss_stall, mem_req_valid, fill_valid, dec_stall;
  logic [15:0]  miss_addr;
  logic [4:0]   miss_dst, dec_src_a, dec_src_b;
  logic [12:0]  mem_req_line;
  logic [1:0]   mem_req_id, fill_id;
  logic [255:0] fill_data, wb_data;
  logic [7:0]   wb_en;
  logic [39:0]  wb_reg;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  mshr_file dut_i (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_dst(miss_dst),
    .miss_stall(miss_stall), .mem_req_valid(mem_req_valid),
    .mem_req_line(mem_req_line), .mem_req_id(mem_req_id),
    .fill_valid(fill_valid), .fill_id(fill_id), .fill_data(fill_data),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_stall(dec_stall)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [255:0] line_pat(input logic [1:0] id);
    logic [255:0] d;
    for (int w = 0; w < 8; w++) d[w*32 +: 32] = 32'hA500_0000 | (32'(id) << 8) | 32'(w);
    return d;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    miss_valid = 1'b0; miss_addr = '0; miss_dst = '0;
    fill_valid = 1'b0; fill_id = '0; fill_data = '0;
    dec_src_a = '0; dec_src_b = '0;
  endtask

  task automatic do_reset();
    idle_in();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int v = 0; v < NV; v++) begin
      logic [46:0] x;
      string tag;
      x = VEC[v];
      @(posedge clk); #1;
      miss_valid = x[42]; miss_addr = x[41:26]; miss_dst = x[25:21];
      fill_valid = x[20]; fill_id = x[19:18]; fill_data = line_pat(x[19:18]);
      dec_src_a = x[17:13]; dec_src_b = '0;
      @(negedge clk);
      tag = $sformatf("R%0d vec%0d", x[46:43], v);
      check({tag, " stall"}, 64'(miss_stall), 64'(x[12]));
      check({tag, " req"},   64'(mem_req_valid), 64'(x[11]));
      if (x[11]) check({tag, " req_id"}, 64'(mem_req_id), 64'(x[10:9]));
      check({tag, " wb_en"}, 64'(wb_en), 64'(x[8:1]));
      check({tag, " dec"},   64'(dec_stall), 64'(x[0]));
    end

    // R1: reset clears pending state; r7 was empty before reset
    @(posedge clk); #1; idle_in();
    do_reset();
    @(posedge clk); #1;
    dec_src_a = 5'd7; dec_src_b = 5'd4;
    @(negedge clk);
    check("R1 dec after reset", 64'(dec_stall), 64'd0);

    // R2: word 0x1234 -> line 0x246, word 4, entry 0
    @(posedge clk); #1;
    miss_valid = 1'b1; miss_addr = 16'h1234; miss_dst = 5'd9;
    @(negedge clk);
    check("R2 req", 64'(mem_req_valid), 64'd1);
    check("R2 line", 64'(mem_req_line), 64'h246);
    check("R1 first id", 64'(mem_req_id), 64'd0);

    // R4: word 6 of same line merges
    @(posedge clk); #1;
    miss_addr = 16'h1236; miss_dst = 5'd10;
    @(negedge clk);
    check("R4 no req", 64'(mem_req_valid), 64'd0);
    check("R4 no stall", 64'(miss_stall), 64'd0);

    // R3: second source port sees r10 empty
    @(posedge clk); #1; idle_in();
    dec_src_b = 5'd10;
    @(negedge clk);
    check("R3 src_b", 64'(dec_stall), 64'd1);

    // R7: fill writes words 4 and 6
    @(posedge clk); #1;
    fill_valid = 1'b1; fill_id = 2'd0; fill_data = line_pat(2'd0);
    dec_src_b = 5'd10;
    @(negedge clk);
    check("R7 wb_en", 64'(wb_en), 64'h50);
    check("R7 reg w4", 64'(wb_reg[4*5 +: 5]), 64'd9);
    check("R7 reg w6", 64'(wb_reg[6*5 +: 5]), 64'd10);
    check("R7 data w4", 64'(wb_data[4*32 +: 32]), 64'hA500_0004);
    check("R7 data w6", 64'(wb_data[6*32 +: 32]), 64'hA500_0006);
    @(posedge clk); #1; idle_in();
    dec_src_a = 5'd9; dec_src_b = 5'd10;
    @(negedge clk);
    check("R7 regs full", 64'(dec_stall), 64'd0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule